// File: doc/BRIEF.md
# Reset Configuration Pin Sampler

This block owns the internal reset-out signal of a chip and uses its fixed length to capture configuration pins at known points of the reset sequence. Either power-on or a reset request starts a pulse on `rst_out` that lasts exactly `RST_LEN` clock cycles. At the first edge of each pulse the wakeup pin is taken as the active wakeup setting. Four edges before the pulse ends, the wakeup pin, the state of the active-low configuration-enable pin and (only when configuration is enabled) the two boot-code pins are written into a status register. On the edge that ends the pulse, the two clock-configuration pins are captured, again only when configuration is enabled on that edge.

From the status register and a boot-identifier-valid flag supplied by the boot loader, the block resolves the boot source: internal flash, serial, external memory, or external memory with external arbitration. External boot fetches its first word from address zero of the device on chip select 0. A missing or invalid identifier makes the chip fall back to serial boot. A parameter can switch off arbitration mode. When it is off, boot code 11 is reported as an error and resolved to serial.

Top module: `rcfg_sampler`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1, `mode_ready` is 0, and `wake_act`, `stat_wake`, `stat_cfg`, `stat_boot` and `clk_cfg` are all 0.
- R2: A reset pulse starts at release of `por_n`, or on an edge where `rst_req` is 1 and `rst_out` is 0. `rst_out` then stays 1 for exactly `RST_LEN` clock edges. `rst_req` seen while `rst_out` is 1, including on the edge that ends the pulse, has no effect.
- R3: `wake_act` takes the value of `wake_pin` at the first clock edge of each reset pulse and holds it until the next pulse.
- R4: At the edge four cycles before `rst_out` falls, `stat_wake` takes `wake_pin` and `stat_cfg` takes the inverse of `cfg_en_n`. Pin changes after that edge do not alter these fields.
- R5: At the same edge, `stat_boot` takes `boot_pins` when `cfg_en_n` is 0 and is written 00 otherwise. Later pin changes are ignored.
- R6: On the edge where `rst_out` falls, `clk_cfg` takes `clk_pins` when `cfg_en_n` is 0 on that edge and is written 00 otherwise. Later pin changes are ignored.
- R7: With `stat_cfg` 0, `boot_src` is 00 (internal flash) when `id_valid` is 1, and 01 (serial) otherwise.
- R8: With `stat_cfg` 1 and `id_valid` 1, the `stat_boot` code maps to `boot_src` as follows: 00 gives 00 (internal), 01 gives 01 (serial), 10 gives 10 (external, no arbitration), and 11 gives 11 (external with arbitration).
- R9: With `stat_cfg` 1 and `id_valid` 0, `boot_src` is 01 (serial) for every boot code.
- R10: With `ARB_EN` 0, a `stat_cfg` of 1 and a `stat_boot` of 11, `arb_err` is 1 and `boot_src` is 01. In every other case `arb_err` is 0.
- R11: `mode_ready` is the inverse of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_req | input | 1 | Request for a new reset pulse |
| cfg_en_n | input | 1 | Configuration enable, active low |
| boot_pins | input | 2 | Boot code pins |
| wake_pin | input | 1 | Wakeup configuration pin |
| clk_pins | input | 2 | Clock configuration pins |
| id_valid | input | 1 | Boot identifier found valid by the loader |
| rst_out | output | 1 | Internal reset-out, active high |
| mode_ready | output | 1 | Boot decision is usable (reset over) |
| wake_act | output | 1 | Wakeup setting in force for this reset |
| stat_wake | output | 1 | Status: latched wakeup pin |
| stat_cfg | output | 1 | Status: configuration enabled at sample |
| stat_boot | output | 2 | Status: latched boot code |
| clk_cfg | output | 2 | Latched clock configuration |
| boot_src | output | 2 | Resolved boot source |
| arb_err | output | 1 | Unsupported arbitration code selected |

## Verification
Two events can fall on the same clock edge: the end of a reset pulse, when the clock pins are captured, and the arrival of a new reset request. The bench raises `rst_req` for exactly the ending edge and expects `rst_out` to fall anyway and to stay low on the next edge. A second overlap concerns the configuration-enable pin. The bench negates it between the boot-code sample and the end of the pulse, and expects the boot code to be kept while the clock field stays 00. In every sweep case, the bench scrambles the pins just after each capture point and compares the latched fields with the values driven before that point.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  typedef enum logic [1:0] {
    BS_INTERNAL = 2'b00,
    BS_SERIAL   = 2'b01,
    BS_EXTERNAL = 2'b10,
    BS_EXT_ARB  = 2'b11
  } boot_src_e;

  // Arbitration code is unusable when the build forbids it
  function automatic logic arb_blocked(input logic cfg_on, input logic [1:0] code,
                                       input logic arb_ok);
    return cfg_on && (code == 2'b11) && !arb_ok;
  endfunction

  function automatic boot_src_e pick_src(input logic cfg_on, input logic [1:0] code,
                                         input logic idv, input logic arb_ok);
    boot_src_e s;
    if (!cfg_on)                          s = idv ? BS_INTERNAL : BS_SERIAL;
    else if (!idv)                        s = BS_SERIAL;
    else if (arb_blocked(cfg_on, code, arb_ok)) s = BS_SERIAL;
    else begin
      case (code)
        2'b00:   s = BS_INTERNAL;
        2'b01:   s = BS_SERIAL;
        2'b10:   s = BS_EXTERNAL;
        default: s = BS_EXT_ARB;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/rcfg_timer.sv
module rcfg_timer #(
  parameter int RST_LEN  = 16,
  parameter int SMP_LEAD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_req,
  output logic rst_out,
  output logic start_stb,
  output logic smp_stb,
  output logic neg_stb
);
  localparam int CW = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_LEN - 1);
  localparam logic [CW-1:0] SMPV = CW'(RST_LEN - 1 - SMP_LEAD);

  logic [CW-1:0] cnt;

  assign start_stb = rst_out && (cnt == '0);
  assign smp_stb   = rst_out && (cnt == SMPV);
  assign neg_stb   = rst_out && (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_out <= 1'b1;
      cnt     <= '0;
    end else if (rst_out) begin
      if (cnt == LAST) begin
        rst_out <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (rst_req) begin
      rst_out <= 1'b1;
      cnt     <= '0;
    end
  end

  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_out && rst_req) |=> (rst_out && start_stb)); // R2
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (rst_out && !neg_stb) |=> rst_out); // R2
  AST_NEG_DROPS: assert property (@(posedge clk) disable iff (!por_n)
    neg_stb |=> !rst_out); // R2
  AST_SMP_BEFORE_NEG: assert property (@(posedge clk) disable iff (!por_n)
    smp_stb |=> (rst_out && !neg_stb)); // R4

endmodule

// File: rtl/rcfg_latch.sv
module rcfg_latch (
  input  logic       clk,
  input  logic       por_n,
  input  logic       start_stb,
  input  logic       smp_stb,
  input  logic       neg_stb,
  input  logic       wake_pin,
  input  logic       cfg_en_n,
  input  logic [1:0] boot_pins,
  input  logic [1:0] clk_pins,
  output logic       wake_act,
  output logic       stat_wake,
  output logic       stat_cfg,
  output logic [1:0] stat_boot,
  output logic [1:0] clk_cfg
);
  logic cfg_on;
  assign cfg_on = !cfg_en_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wake_act  <= 1'b0;
      stat_wake <= 1'b0;
      stat_cfg  <= 1'b0;
      stat_boot <= 2'b00;
      clk_cfg   <= 2'b00;
    end else begin
      if (start_stb) wake_act <= wake_pin;
      if (smp_stb) begin
        stat_wake <= wake_pin;
        stat_cfg  <= cfg_on;
        stat_boot <= cfg_on ? boot_pins : 2'b00;
      end
      if (neg_stb) clk_cfg <= cfg_on ? clk_pins : 2'b00;
    end
  end

  AST_BOOT_GATED: assert property (@(posedge clk) disable iff (!por_n)
    (smp_stb && cfg_en_n) |=> (stat_boot == 2'b00)); // R5
  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !smp_stb |=> ($stable(stat_boot) && $stable(stat_wake))); // R4
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !neg_stb |=> $stable(clk_cfg)); // R6
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !start_stb |=> $stable(wake_act)); // R3

endmodule

// File: rtl/rcfg_decode.sv
module rcfg_decode
  import rcfg_pkg::*;
#(
  parameter bit ARB_EN = 1'b1
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       stat_cfg,
  input  logic [1:0] stat_boot,
  input  logic       id_valid,
  output logic [1:0] boot_src,
  output logic       arb_err
);
  boot_src_e src;

  always_comb begin
    src     = pick_src(stat_cfg, stat_boot, id_valid, ARB_EN);
    arb_err = arb_blocked(stat_cfg, stat_boot, ARB_EN);
  end
  assign boot_src = src;

  AST_ERR_SERIAL: assert property (@(posedge clk) disable iff (!por_n)
    arb_err |-> (boot_src == 2'b01)); // R10
  AST_CODE01_SERIAL: assert property (@(posedge clk) disable iff (!por_n)
    (stat_cfg && stat_boot == 2'b01) |-> (boot_src == 2'b01)); // R8
  AST_NOID_SERIAL: assert property (@(posedge clk) disable iff (!por_n)
    (stat_cfg && !id_valid) |-> (boot_src == 2'b01)); // R9

endmodule

// File: rtl/rcfg_sampler.sv
module rcfg_sampler #(
  parameter int RST_LEN  = 16,
  parameter bit ARB_EN   = 1'b1
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic       cfg_en_n,
  input  logic [1:0] boot_pins,
  input  logic       wake_pin,
  input  logic [1:0] clk_pins,
  input  logic       id_valid,
  output logic       rst_out,
  output logic       mode_ready,
  output logic       wake_act,
  output logic       stat_wake,
  output logic       stat_cfg,
  output logic [1:0] stat_boot,
  output logic [1:0] clk_cfg,
  output logic [1:0] boot_src,
  output logic       arb_err
);
  localparam int SMP_LEAD = 4;

  logic start_stb, smp_stb, neg_stb;

  rcfg_timer #(.RST_LEN(RST_LEN), .SMP_LEAD(SMP_LEAD)) u_timer (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .rst_out(rst_out),
    .start_stb(start_stb), .smp_stb(smp_stb), .neg_stb(neg_stb)
  );

  rcfg_latch u_latch (
    .clk(clk), .por_n(por_n), .start_stb(start_stb), .smp_stb(smp_stb),
    .neg_stb(neg_stb), .wake_pin(wake_pin), .cfg_en_n(cfg_en_n),
    .boot_pins(boot_pins), .clk_pins(clk_pins), .wake_act(wake_act),
    .stat_wake(stat_wake), .stat_cfg(stat_cfg), .stat_boot(stat_boot),
    .clk_cfg(clk_cfg)
  );

  rcfg_decode #(.ARB_EN(ARB_EN)) u_decode (
    .clk(clk), .por_n(por_n), .stat_cfg(stat_cfg), .stat_boot(stat_boot),
    .id_valid(id_valid), .boot_src(boot_src), .arb_err(arb_err)
  );

  assign mode_ready = !rst_out;

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> mode_ready); // R11

  initial begin
    AST_LEN_OK: assert (RST_LEN > SMP_LEAD + 1); // R2
  end

endmodule

// File: tb/test_rcfg_sampler.sv
module test_rcfg_sampler;
  localparam int L = 16;

  logic clk = 1'b0;
  logic por_n, rst_req, cfg_en_n, wake_pin, id_valid;
  logic [1:0] boot_pins, clk_pins;

  logic       ro_a, rdy_a, wa_a, sw_a, sc_a, err_a;
  logic [1:0] sb_a, cc_a, src_a;
  logic       ro_b, rdy_b, wa_b, sw_b, sc_b, err_b;
  logic [1:0] sb_b, cc_b, src_b;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rcfg_sampler #(.RST_LEN(L), .ARB_EN(1'b1)) i_rcfg_sampler (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .cfg_en_n(cfg_en_n),
    .boot_pins(boot_pins), .wake_pin(wake_pin), .clk_pins(clk_pins),
    .id_valid(id_valid), .rst_out(ro_a), .mode_ready(rdy_a), .wake_act(wa_a),
    .stat_wake(sw_a), .stat_cfg(sc_a), .stat_boot(sb_a), .clk_cfg(cc_a),
    .boot_src(src_a), .arb_err(err_a)
  );

  rcfg_sampler #(.RST_LEN(L), .ARB_EN(1'b0)) i_rcfg_sampler_noarb (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .cfg_en_n(cfg_en_n),
    .boot_pins(boot_pins), .wake_pin(wake_pin), .clk_pins(clk_pins),
    .id_valid(id_valid), .rst_out(ro_b), .mode_ready(rdy_b), .wake_act(wa_b),
    .stat_wake(sw_b), .stat_cfg(sc_b), .stat_boot(sb_b), .clk_cfg(cc_b),
    .boot_src(src_b), .arb_err(err_b)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected boot source, written as arithmetic on the codes
  function automatic int exp_src(input int cfg, input int code, input int idv, input int arb);
    if (cfg == 0) return 1 - idv;
    if (idv == 0 || code == 1) return 1;
    if (code == 3 && arb == 0) return 1;
    return code;
  endfunction

  // mode 0: plain; 1: config disabled after sample; 2: request on ending edge
  task automatic run_case(input int cfg, input int b, input int w, input int cp,
                          input int idv, input int mode);
    int eb, ec, cfg_neg;
    @(negedge clk);
    cfg_en_n  = (cfg == 0);
    boot_pins = 2'(b);
    wake_pin  = w[0];
    clk_pins  = 2'(cp);
    id_valid  = idv[0];
    rst_req   = 1'b1;
    cfg_neg   = (mode == 1) ? 0 : cfg;
    for (int k = 1; k <= L + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        rst_req = 1'b0;
        check("R2 pulse begins", ro_a, 1);
      end
      if (k == 2) check("R3 wake at start", wa_a, w);
      if (k == L - 3) begin
        boot_pins = ~boot_pins;
        wake_pin  = ~wake_pin;
        if (mode == 1) cfg_en_n = 1'b1;
      end
      if (k == L) begin
        check("R2 still in reset", ro_a, 1);
        if (mode == 2) rst_req = 1'b1;
      end
      if (k == L + 1) begin
        rst_req  = 1'b0;
        clk_pins = ~clk_pins;
        check("R2 pulse length", ro_a, 0);
        check("R11 ready", rdy_a, 1);
      end
    end
    eb = cfg ? b : 0;
    ec = cfg_neg ? cp : 0;
    check("R3 wake held", wa_a, w);
    check("R4 stat_wake", sw_a, w);
    check("R4 stat_cfg", sc_a, cfg);
    check("R5 stat_boot", sb_a, eb);
    check("R6 clk_cfg", cc_a, ec);
    check("R7/R8/R9 boot_src", src_a, exp_src(cfg, eb, idv, 1));
    check("R10 no err with arb", err_a, 0);
    check("R10 boot_src no-arb", src_b, exp_src(cfg, eb, idv, 0));
    check("R10 arb_err", err_b, (cfg == 1 && b == 3) ? 1 : 0);
    if (mode == 2) begin
      @(negedge clk);
      check("R2 request on ending edge ignored", ro_a, 0);
    end
  endtask

  initial begin
    int hi;
    por_n = 1'b0; rst_req = 1'b0; cfg_en_n = 1'b0; boot_pins = 2'b11;
    wake_pin = 1'b1; clk_pins = 2'b11; id_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rst_out", ro_a, 1);
    check("R1 mode_ready", rdy_a, 0);
    check("R1 status zero", {wa_a, sw_a, sc_a, sb_a, cc_a}, 0);
    por_n = 1'b1;
    hi = 0;
    for (int k = 0; k < 4 * L; k++) begin
      @(negedge clk);
      if (ro_a) hi++;
      else break;
    end
    check("R2 power-on pulse length", hi, L - 1);
    check("R4 power-on stat_wake", sw_a, 1);
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 4; b++)
        for (int w = 0; w < 2; w++)
          for (int v = 0; v < 2; v++)
            run_case(c, b, w, (b + w + v + c) % 4, v, 0);
    run_case(1, 2, 1, 3, 1, 1);
    run_case(1, 3, 0, 1, 1, 1);
    run_case(1, 1, 1, 2, 0, 1);
    run_case(1, 0, 0, 2, 1, 2);
    run_case(0, 3, 1, 1, 1, 2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule